// File: doc/BRIEF.md
# Sampled Four-Way Select Router

This block takes one active-low chip-select from a bus controller and steers it to one of four downstream select lanes. A two-bit lane address picks the lane. Each lane carries a data value, which always equals the incoming select, and an output-enable bit. A lane whose enable is low is treated as floating: the pads are released and board pull-ups set the idle level. Enable bit `i` belongs to address value `i`, so address 0 enables bit 0 and address 3 enables bit 3.

The address is not used as it arrives. It first passes through a synchronizer chain. A free-running tick, divided down from the core clock, then samples it. A new address takes over the routing only after a run of consecutive samples all return that value. The delay from an address change to the new routing therefore varies, but it has a fixed upper bound. A short spike on the address, or a skewed change of the two address bits, cannot move the routing unless the spike value survives the full run of samples.

The enable vector is registered and is recomputed whole from the qualified address. In a changeover, the old lane drops in the same cycle as the new lane rises. No third lane is ever enabled, even for one cycle.

Top module: `sel_route4`

## Requirements
- R1: After reset all four enables are 0. They stay 0 until the first address has been qualified, which needs `QUAL_SAMPLES` sample ticks. With the defaults and a constant address, the enables become nonzero exactly `2*TICK_DIV+1` clock edges after reset is released.
- R2: In every cycle, all four lane data outputs equal `csel_in_n`, whatever the enables are.
- R3: At most one enable bit is ever high. Once an address `a` (0..3) has been qualified, the high enable is bit `a`.
- R4: The address is sampled once every `TICK_DIV` core clock cycles, on a free-running tick that starts counting at reset release.
- R5: A new address changes the routing only after `QUAL_SAMPLES` consecutive samples agree on it. With the defaults (two synchronizer stages, two samples), the delay from an input change to the new enable lies between `TICK_DIV+4` and `2*TICK_DIV+3` clock edges inclusive.
- R6: An address excursion shorter than `TICK_DIV` cycles, followed by a return to the previous address, leaves the enables unchanged.
- R7: When the routing moves from lane `x` to lane `y`, bit `x` falls in the same cycle as bit `y` rises. No other lane is enabled at any point. After the first qualification the enable vector is never all zero.
- R8: The enable vector changes only in the cycle after a qualification event, and it moves to its new value in a single step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csel_in_n | input | 1 | Active-low select from the bus controller |
| addr_in | input | 2 | Lane address, asynchronous to `clk` |
| csel_out_n | output | 4 | Per-lane select data, each a copy of `csel_in_n` |
| csel_oe | output | 4 | Per-lane output enable; 0 means the lane floats |

## Verification
The bound checker watches four properties on every clock: the enable vector is one-hot-or-zero, it never returns to zero once enabled, every change in it follows a qualification event, and every qualification is backed by enough agreeing samples in the checker's own sample model. The tick period and the reset-to-first-qualification rule are also checked cycle by cycle. Some properties need a stimulus history, so only the bench scenarios can show them. These are the exact latency window after an address change, the rejection of a short address spike, the exact reset-to-enable cycle, and the data lanes following the input select.

// File: rtl/sr4_pkg.sv
package sr4_pkg;
  localparam int unsigned NUM_LANES = 4;
  localparam int unsigned ADDR_W    = $clog2(NUM_LANES);

  typedef logic [ADDR_W-1:0]    lane_addr_t;
  typedef logic [NUM_LANES-1:0] lane_vec_t;

  // One-hot lane mask for a qualified address.
  function automatic lane_vec_t lane_mask(input lane_addr_t a);
    lane_vec_t m;
    m = '0;
    m[a] = 1'b1;
    return m;
  endfunction

  // Saturating increment used for sample run lengths.
  function automatic int unsigned run_step(input int unsigned cur, input int unsigned cap);
    return (cur >= cap) ? cap : cur + 1;
  endfunction
endpackage

// File: rtl/sr4_tick.sv
module sr4_tick #(
  parameter int unsigned TICK_DIV = 130
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sr4_sync.sv
module sr4_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= '0;
          else        chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sr4_qual.sv
module sr4_qual
  import sr4_pkg::*;
#(
  parameter int unsigned QUAL_SAMPLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  lane_addr_t samp_addr,
  output lane_addr_t qual_addr,
  output logic       qual_valid,
  output logic       qual_update
);
  localparam int unsigned RUN_W = $clog2(QUAL_SAMPLES + 1);

  lane_addr_t       cand_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_nxt;
  logic             run_met;
  logic             differs;

  always_comb begin
    if (samp_addr == cand_q && run_q != '0)
      run_nxt = RUN_W'(run_step(int'(run_q), QUAL_SAMPLES));
    else
      run_nxt = RUN_W'(1);
    run_met = (int'(run_nxt) >= QUAL_SAMPLES);
    differs = !qual_valid || (samp_addr != qual_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q      <= '0;
      run_q       <= '0;
      qual_addr   <= '0;
      qual_valid  <= 1'b0;
      qual_update <= 1'b0;
    end else begin
      qual_update <= 1'b0;
      if (tick) begin
        cand_q <= samp_addr;
        run_q  <= run_nxt;
        if (run_met && differs) begin
          qual_addr   <= samp_addr;
          qual_valid  <= 1'b1;
          qual_update <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sr4_route.sv
module sr4_route
  import sr4_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csel_in_n,
  input  lane_addr_t qual_addr,
  input  logic       qual_valid,
  output lane_vec_t  csel_out_n,
  output lane_vec_t  csel_oe
);
  lane_vec_t oe_nxt;

  assign oe_nxt = qual_valid ? lane_mask(qual_addr) : '0;

  // Whole-vector register: old bit falls and new bit rises on one edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csel_oe <= '0;
    else        csel_oe <= oe_nxt;
  end

  genvar i;
  generate
    for (i = 0; i < NUM_LANES; i++) begin : g_lane
      assign csel_out_n[i] = csel_in_n;
    end
  endgenerate
endmodule

// File: rtl/sel_route4.sv
module sel_route4
  import sr4_pkg::*;
#(
  parameter int unsigned TICK_DIV     = 130,
  parameter int unsigned QUAL_SAMPLES = 2,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 csel_in_n,
  input  logic [ADDR_W-1:0]    addr_in,
  output logic [NUM_LANES-1:0] csel_out_n,
  output logic [NUM_LANES-1:0] csel_oe
);
  logic       tick;
  lane_addr_t sync_addr;
  lane_addr_t qual_addr;
  logic       qual_valid;
  logic       qual_update;

  sr4_tick #(.TICK_DIV(TICK_DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  sr4_sync #(.WIDTH(ADDR_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(addr_in), .q(sync_addr)
  );

  sr4_qual #(.QUAL_SAMPLES(QUAL_SAMPLES)) qual_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .samp_addr(sync_addr),
    .qual_addr(qual_addr), .qual_valid(qual_valid), .qual_update(qual_update)
  );

  sr4_route route_i (
    .clk(clk), .rst_n(rst_n), .csel_in_n(csel_in_n),
    .qual_addr(qual_addr), .qual_valid(qual_valid),
    .csel_out_n(csel_out_n), .csel_oe(csel_oe)
  );
endmodule

// File: rtl/sr4_checker.sv
module sr4_checker
  import sr4_pkg::*;
#(
  parameter int unsigned TICK_DIV     = 130,
  parameter int unsigned QUAL_SAMPLES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input lane_addr_t sync_addr,
  input lane_addr_t qual_addr,
  input logic       qual_update,
  input lane_vec_t  csel_oe
);
  localparam int unsigned TC_W = $clog2(TICK_DIV + 1);
  localparam int unsigned RC_W = $clog2(QUAL_SAMPLES + 1);

  logic [TC_W-1:0] ck_tcnt;
  lane_addr_t      ck_cand;
  logic [RC_W-1:0] ck_run;
  logic            ck_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_tcnt <= '0;
      ck_cand <= '0;
      ck_run  <= '0;
      ck_seen <= 1'b0;
    end else begin
      ck_tcnt <= tick ? '0 : ck_tcnt + 1'b1;
      if (tick) begin
        if (ck_run != '0 && sync_addr == ck_cand) begin
          if (int'(ck_run) < QUAL_SAMPLES) ck_run <= ck_run + 1'b1;
        end else begin
          ck_cand <= sync_addr;
          ck_run  <= RC_W'(1);
        end
      end
      if (qual_update) ck_seen <= 1'b1;
    end
  end

  // R1: no enable before the first qualification
  p_idle_until_qual_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_seen |-> csel_oe == '0);

  // R3: at most one lane enabled
  p_oe_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(csel_oe));

  // R3: the enabled lane is the qualified address
  p_oe_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    qual_update |=> csel_oe[$past(qual_addr)]);

  // R4: tick period
  p_tick_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> int'(ck_tcnt) == TICK_DIV - 1);

  // R5: enough agreeing samples behind every qualification
  p_run_backed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    qual_update |-> (int'(ck_run) >= QUAL_SAMPLES && ck_cand == qual_addr));

  // R7: once enabled, never all lanes off
  p_no_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(csel_oe) != '0 |-> csel_oe != '0);

  // R8: enables change only after a qualification event
  p_change_after_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
    csel_oe != $past(csel_oe) |-> $past(qual_update));
endmodule

bind sel_route4 sr4_checker #(
  .TICK_DIV(TICK_DIV), .QUAL_SAMPLES(QUAL_SAMPLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sync_addr(sync_addr),
  .qual_addr(qual_addr), .qual_update(qual_update), .csel_oe(csel_oe)
);

// File: tb/sel_route4_tb_top.sv
module sel_route4_tb_top;
  localparam int TD    = 130;
  localparam int LAT_MIN = TD + 4;
  localparam int LAT_MAX = 2 * TD + 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csel_in_n = 1'b1;
  logic [1:0] addr_in = 2'd2;
  logic [3:0] csel_out_n;
  logic [3:0] csel_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sel_route4 #(.TICK_DIV(TD)) dut_i (
    .clk(clk), .rst_n(rst_n), .csel_in_n(csel_in_n), .addr_in(addr_in),
    .csel_out_n(csel_out_n), .csel_oe(csel_oe)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [3:0] mask_of(input logic [1:0] a);
    return 4'b0001 << a;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // R1: exact first enable with address 2 held through reset
  task automatic t_reset();
    check("R1 in reset", csel_oe, 4'b0000);
    @(negedge clk) rst_n = 1'b1;
    edges(TD + 2);
    check("R1 before first qualification", csel_oe, 4'b0000);
    edges(2 * TD - (TD + 2));
    check("R1 edge 2*TD", csel_oe, 4'b0000);
    edges(1);
    check("R1 R3 first enable", csel_oe, mask_of(2'd2));
  endtask

  // R2: data lanes follow input select
  task automatic t_data();
    csel_in_n = 1'b0; #1;
    check("R2 low", csel_out_n, 4'b0000);
    csel_in_n = 1'b1; #1;
    check("R2 high", csel_out_n, 4'b1111);
    edges(1);
    csel_in_n = 1'b0; #1;
    check("R2 low again", csel_out_n, 4'b0000);
  endtask

  // R3 R4 R5 R7 R8: latency window and clean changeover
  task automatic t_switch(input logic [1:0] nxt);
    logic [3:0] old_m, new_m;
    int lat = -1;
    bit stray = 0;
    old_m = csel_oe;
    new_m = mask_of(nxt);
    addr_in = nxt;
    for (int k = 1; k <= LAT_MAX + 2; k++) begin
      @(negedge clk);
      if (csel_oe != old_m && csel_oe != new_m) stray = 1;
      if (lat < 0 && csel_oe == new_m) lat = k;
    end
    check("R7 R8 no stray lane during changeover", {3'b0, stray}, 4'b0000);
    check("R3 new lane", csel_oe, new_m);
    n_chk++;
    if (lat < LAT_MIN || lat > LAT_MAX) begin
      n_bad++;
      $display("FAIL R4 R5 latency actual=%0d expected=%0d..%0d", lat, LAT_MIN, LAT_MAX);
    end
  endtask

  // R6: short address spike ignored
  task automatic t_spike(input logic [1:0] spike, input int len);
    logic [3:0] keep;
    logic [1:0] home;
    bit moved = 0;
    keep = csel_oe;
    home = addr_in;
    addr_in = spike;
    edges(len);
    addr_in = home;
    for (int k = 0; k < 3 * TD; k++) begin
      @(negedge clk);
      if (csel_oe != keep) moved = 1;
    end
    check("R6 spike ignored", {3'b0, moved}, 4'b0000);
    check("R6 lane kept", csel_oe, keep);
  endtask

  initial begin
    t_reset();
    t_data();
    t_switch(2'd3);
    t_switch(2'd0);
    edges(17);
    t_switch(2'd1);
    edges(53);
    t_switch(2'd2);
    t_spike(2'd0, TD - 10);
    t_spike(2'd3, 5);
    edges(7);
    t_switch(2'd3);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule